// File: doc/BRIEF.md
# Floating-Point Unit Reservation Tracker

This block sits at the issue point of a floating-point queue and decides, one operation per cycle, whether the operation can start now. The execution resources are an adder and a multiplier group. The multiplier group holds three sub-units: multiply, divide and square root. Each sub-unit keeps its own reservation, so a long divide does not block a multiply or a square root. The block does no arithmetic. It books structural occupancy only, and it reports the result latency of each operation it accepts.

Each operation arrives with a class code, a precision bit and a hint that says whether its consumer is a fused multiply-add. If the sub-unit the operation needs is free, the block raises accept in the same cycle. It then loads that sub-unit's down-counter with the remaining occupancy. A fused multiply-add books the adder in its issue cycle and the multiply sub-unit in the following cycle. An operation that cannot start sees accept held low, and it is presented again until its sub-unit frees up.

Top module: `fpu_resv_tracker`

## Requirements
- R1: After reset all four busy flags are 0. `op_accept_o` is 0 whenever `op_valid_i` is 0. Busy bit 0 is the adder, bit 1 multiply, bit 2 divide and bit 3 square root.
- R2: Class 0 (add, abs, negate, compare) occupies the adder for 1 cycle and reports latency 2. Such operations can be accepted on every cycle.
- R3: Class 1 (multiply, FP move, FP conditional move, move from the FP file) occupies the multiply sub-unit for 1 cycle and reports latency 2.
- R4: Class 2 (integer-to-single conversion) holds the adder for 2 cycles and reports latency 4. An adder operation in the next cycle is refused.
- R5: Class 3 (any other conversion) holds the adder for 1 cycle and reports latency 2.
- R6: Class 4 (fused multiply-add) occupies the adder in its issue cycle and the multiply sub-unit in the next cycle, and reports latency 4. A class 1 operation in that next cycle is refused.
- R7: A class 4 operation with `op_fma_dep_i`=1 reports latency 2. Back-to-back class 4 operations are accepted on consecutive cycles.
- R8: A class 4 operation is refused while the adder is still held by an earlier operation.
- R9: Class 5 (divide) holds the divide sub-unit for 14 cycles (single, `op_dbl_i`=0) or 21 cycles (double), with latency 12 or 19.
- R10: Class 6 (square root) holds the square-root sub-unit for 20 cycles (single) or 35 cycles (double), with latency 18 or 33.
- R11: Class 7 (reciprocal square root) holds the square-root sub-unit for 20 or 35 cycles, with latency 30 (single) or 52 (double).
- R12: Divide, square root, multiply and adder can all be occupied at the same time.
- R13: An operation whose sub-unit is busy is refused. It is accepted in the first cycle the sub-unit is free. Each reservation counter decrements by one per cycle until it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_class_i | input | 3 | Operation class code (0 to 7) |
| op_dbl_i | input | 1 | 1 = double precision |
| op_fma_dep_i | input | 1 | 1 = the consumer of this result is a fused multiply-add |
| op_accept_o | output | 1 | The operation starts this cycle |
| op_latency_o | output | LAT_W | Result latency in cycles; meaningful while accept is high |
| unit_busy_o | output | 4 | Occupancy flags per sub-unit, in the bit order given in R1 |

## Verification
The embedded assertions check the following on every cycle:
- accept never rises without a valid operation;
- each counter steps down by exactly one;
- an accepted divide or square-root operation never finds its sub-unit busy;
- a conversion or fused multiply-add leaves the expected follow-on reservation.

Some properties can only be shown by the directed scenarios:
- the exact hold lengths for each precision, such as the first accepting cycle after a 35-cycle square root;
- the latency values;
- the fused multiply-add chain shortening;
- several sub-units working in parallel.

// File: rtl/fpu_resv_pkg.sv
package fpu_resv_pkg;
  typedef enum logic [2:0] {
    CL_FADD    = 3'd0,
    CL_FMUL    = 3'd1,
    CL_CVT_I2S = 3'd2,
    CL_CVT     = 3'd3,
    CL_FMA     = 3'd4,
    CL_DIV     = 3'd5,
    CL_SQRT    = 3'd6,
    CL_RSQRT   = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    U_ADD  = 2'd0,
    U_MUL  = 2'd1,
    U_DIV  = 2'd2,
    U_SQRT = 2'd3
  } unit_e;

  localparam int NUM_UNITS = 4;

  localparam int HOLD_DIV_S  = 14;
  localparam int HOLD_DIV_D  = 21;
  localparam int HOLD_SQRT_S = 20;
  localparam int HOLD_SQRT_D = 35;
  localparam int HOLD_I2S    = 2;

  localparam int LAT_SHORT   = 2;
  localparam int LAT_I2S     = 4;
  localparam int LAT_FMA     = 4;
  localparam int LAT_FMA_DEP = 2;
  localparam int LAT_DIV_S   = 12;
  localparam int LAT_DIV_D   = 19;
  localparam int LAT_SQRT_S  = 18;
  localparam int LAT_SQRT_D  = 33;
  localparam int LAT_RSQ_S   = 30;
  localparam int LAT_RSQ_D   = 52;
endpackage

// File: rtl/fpu_resv_decode.sv
module fpu_resv_decode
  import fpu_resv_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LAT_W = 6
) (
  input  logic [2:0]       class_i,
  input  logic             dbl_i,
  input  logic             fma_dep_i,
  output unit_e            unit_o,
  output logic             fma_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [LAT_W-1:0] lat_o
);
  op_class_e cls;
  assign cls = op_class_e'(class_i);

  always_comb begin
    unit_o = U_ADD;
    fma_o  = 1'b0;
    hold_o = CNT_W'(1);
    lat_o  = LAT_W'(LAT_SHORT);
    unique case (cls)
      CL_FADD, CL_CVT: ;
      CL_FMUL: unit_o = U_MUL;
      CL_CVT_I2S: begin
        hold_o = CNT_W'(HOLD_I2S);
        lat_o  = LAT_W'(LAT_I2S);
      end
      CL_FMA: begin
        fma_o = 1'b1;
        lat_o = fma_dep_i ? LAT_W'(LAT_FMA_DEP) : LAT_W'(LAT_FMA);
      end
      CL_DIV: begin
        unit_o = U_DIV;
        hold_o = dbl_i ? CNT_W'(HOLD_DIV_D) : CNT_W'(HOLD_DIV_S);
        lat_o  = dbl_i ? LAT_W'(LAT_DIV_D) : LAT_W'(LAT_DIV_S);
      end
      CL_SQRT: begin
        unit_o = U_SQRT;
        hold_o = dbl_i ? CNT_W'(HOLD_SQRT_D) : CNT_W'(HOLD_SQRT_S);
        lat_o  = dbl_i ? LAT_W'(LAT_SQRT_D) : LAT_W'(LAT_SQRT_S);
      end
      CL_RSQRT: begin
        unit_o = U_SQRT;
        hold_o = dbl_i ? CNT_W'(HOLD_SQRT_D) : CNT_W'(HOLD_SQRT_S);
        lat_o  = dbl_i ? LAT_W'(LAT_RSQ_D) : LAT_W'(LAT_RSQ_S);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpu_resv_cnt.sv
module fpu_resv_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R13
  AST_CNT_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R13
endmodule

// File: rtl/fpu_resv_tracker.sv
module fpu_resv_tracker
  import fpu_resv_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LAT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_class_i,
  input  logic             op_dbl_i,
  input  logic             op_fma_dep_i,
  output logic             op_accept_o,
  output logic [LAT_W-1:0] op_latency_o,
  output logic [3:0]       unit_busy_o
);
  unit_e            dec_unit;
  logic             dec_fma;
  logic [CNT_W-1:0] dec_hold;
  logic [LAT_W-1:0] dec_lat;

  logic [CNT_W-1:0] cnt      [NUM_UNITS];
  logic [CNT_W-1:0] load_val [NUM_UNITS];
  logic [NUM_UNITS-1:0] load;
  logic [NUM_UNITS-1:0] unit_free;
  logic target_free;

  fpu_resv_decode #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_decode (
    .class_i  (op_class_i),
    .dbl_i    (op_dbl_i),
    .fma_dep_i(op_fma_dep_i),
    .unit_o   (dec_unit),
    .fma_o    (dec_fma),
    .hold_o   (dec_hold),
    .lat_o    (dec_lat)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam bit IS_MUL = (u == int'(U_MUL));
    always_comb begin
      load[u]     = op_accept_o && ((dec_unit == unit_e'(u)) || (IS_MUL && dec_fma));
      // fma books the multiplier for exactly the next cycle
      load_val[u] = (IS_MUL && dec_fma) ? CNT_W'(1) : dec_hold - CNT_W'(1);
    end
    assign unit_free[u]   = (cnt[u] == '0);
    assign unit_busy_o[u] = !unit_free[u];

    fpu_resv_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[u]),
      .load_val_i(load_val[u]),
      .cnt_o     (cnt[u])
    );
  end

  // fma: adder free now, multiplier free by next cycle
  assign target_free = dec_fma ? (unit_free[U_ADD] && (cnt[U_MUL] <= CNT_W'(1)))
                               : unit_free[dec_unit];
  assign op_accept_o  = op_valid_i && target_free;
  assign op_latency_o = dec_lat;

  AST_NO_SPURIOUS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !op_accept_o); // R1
  AST_DIV_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_accept_o && op_class_i == 3'd5) |-> !unit_busy_o[2]); // R13
  AST_SQRT_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_accept_o && (op_class_i == 3'd6 || op_class_i == 3'd7)) |-> !unit_busy_o[3]); // R13
  AST_FMA_BOOKS_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_accept_o && op_class_i == 3'd4) |=> unit_busy_o[1]); // R6
  AST_I2S_HOLDS_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_accept_o && op_class_i == 3'd2) |=> unit_busy_o[0]); // R4
  AST_DIV_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_accept_o && op_class_i == 3'd5) |=> unit_busy_o[2]); // R9
endmodule

// File: tb/fpu_resv_tracker_bench.sv
module fpu_resv_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] cls = 3'd0;
  logic       dbl = 1'b0;
  logic       dep = 1'b0;
  logic       accept;
  logic [5:0] lat;
  logic [3:0] busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpu_resv_tracker u_fpu_resv_tracker (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_class_i(cls),
    .op_dbl_i(dbl), .op_fma_dep_i(dep), .op_accept_o(accept),
    .op_latency_o(lat), .unit_busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one op for one cycle; check accept and latency
  task automatic issue(input int c, input bit d, input bit fd, input bit exp_acc,
                       input int exp_lat, input string req);
    @(negedge clk);
    valid = 1'b1; cls = 3'(c); dbl = d; dep = fd;
    #2;
    chk(accept == exp_acc, req, int'(accept), int'(exp_acc));
    if (exp_acc) chk(int'(lat) == exp_lat, req, int'(lat), exp_lat);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    chk(busy == 4'b0, "R1", int'(busy), 0);
    chk(accept == 1'b0, "R1", int'(accept), 0);
  endtask

  task automatic t_add_mul();
    issue(0, 0, 0, 1, 2, "R2");
    issue(0, 0, 0, 1, 2, "R2");
    issue(1, 0, 0, 1, 2, "R3");
    issue(1, 1, 0, 1, 2, "R3");
    issue(3, 0, 0, 1, 2, "R5");
    issue(0, 0, 0, 1, 2, "R5");
    idle(3);
  endtask

  task automatic t_cvt_i2s();
    issue(2, 0, 0, 1, 4, "R4");
    issue(0, 0, 0, 0, 0, "R4");
    issue(0, 0, 0, 1, 2, "R4");
    idle(3);
  endtask

  task automatic t_fma();
    issue(4, 0, 0, 1, 4, "R6");
    issue(1, 0, 0, 0, 0, "R6");
    issue(1, 0, 0, 1, 2, "R6");
    idle(3);
    issue(4, 0, 1, 1, 2, "R7");
    issue(4, 0, 1, 1, 2, "R7");
    issue(4, 1, 0, 1, 4, "R7");
    idle(3);
    issue(2, 0, 0, 1, 4, "R8");
    issue(4, 0, 0, 0, 0, "R8");
    issue(4, 0, 0, 1, 4, "R8");
    idle(3);
  endtask

  // op held for 'hold' cycles: hold-1 refusals then accept
  task automatic t_long(input int c, input bit d, input int hold, input int lat_v,
                        input string req);
    issue(c, d, 0, 1, lat_v, req);
    for (int i = 1; i < hold; i++) issue(c, d, 0, 0, 0, "R13");
    issue(c, d, 0, 1, lat_v, req);
    idle(40);
    #2;
    chk(busy == 4'b0, req, int'(busy), 0);
  endtask

  task automatic t_parallel();
    issue(5, 1, 0, 1, 19, "R12");
    issue(6, 0, 0, 1, 18, "R12");
    issue(1, 0, 0, 1, 2, "R12");
    issue(0, 0, 0, 1, 2, "R12");
    #2;
    chk(busy[3:2] == 2'b11, "R12", int'(busy), 12);
    issue(7, 0, 0, 0, 0, "R13");
    idle(40);
  endtask

  initial begin
    #55 rst_n = 1'b1;
    t_reset();
    t_add_mul();
    t_cvt_i2s();
    t_fma();
    t_long(5, 0, 14, 12, "R9");
    t_long(5, 1, 21, 19, "R9");
    t_long(6, 0, 20, 18, "R10");
    t_long(6, 1, 35, 33, "R10");
    t_long(7, 0, 20, 30, "R11");
    t_long(7, 1, 35, 52, "R11");
    t_parallel();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule